// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, for one control/status register access per cycle, whether the access is permitted on a hart with machine, supervisor and user privilege levels. It takes a 12-bit register address, the current privilege, a write flag and a handful of configuration inputs: the trap-virtual-memory bit, the machine and supervisor counter-enable masks, flags for the optional supervisor mode, user mode and hardware performance counters, the number of memory-protection entries, and whether the hart runs in 32-bit mode.

The result is a single flag, registered on the rising clock edge, that the pipeline uses to raise an illegal-instruction exception when it is low. Legality has five parts, and all of them must hold. The register must exist. The read-only and minimum-privilege fields in the address must allow the access. Supervisor access to the address-translation register must not be blocked. User counter reads must be enabled. The entropy seed register must be accessed correctly. Privilege is encoded as user 2'b00, supervisor 2'b01 and machine 2'b11.

Top module: `csrchk_top`

## Requirements
- R1: While reset is high, `legal_o` is low at the next edge. Otherwise `legal_o` shows the verdict for the inputs sampled at the previous rising edge.
- R2: An address that names no defined register is illegal at every privilege. Undefined examples are 0x123, 0x321 and 0x322. Defined examples are 0x300 and 0x320.
- R3: A write to any address whose bits [11:10] are 2'b11 is illegal. A read of such an address may be legal.
- R4: An access is legal only if the privilege code is unsigned greater than or equal to address bits [9:8]. Privilege codes are U=2'b00, S=2'b01 and M=2'b11.
- R5: Address 0x180 is illegal in supervisor mode while the trap-virtual-memory input is 1. In machine mode it stays legal.
- R6: For addresses 0xC00 to 0xC1F, bit address[4:0] of the enable masks gates the access. Machine mode is always allowed. Supervisor mode needs the machine bit. User mode needs the machine bit, and also the supervisor bit when supervisor mode is present.
- R7: Address 0x015 is illegal for every read. A write to it is legal only in machine mode.
- R8: Address 0x3A0+i (i in 0..15) exists only if i is less than the protection-entry count and either i is even or 32-bit mode is on.
- R9: Addresses 0x3B0 to 0x3EF exist only if (address − 0x3B0) is less than the protection-entry count.
- R10: Addresses 0x310, 0xB80, 0xB82 and 0xC80 to 0xC82 exist only in 32-bit mode. Addresses 0x31A and 0xC80 to 0xC82 also need user mode.
- R11: Performance entries with index 3 to 31 exist only when the performance-counter flag is set. These are 0x323..0x33F, 0xB03..0xB1F, 0xC03..0xC1F, and in 32-bit mode 0xB83..0xB9F and 0xC83..0xC9F. The 0xCxx entries also need user mode.
- R12: Addresses 0x100, 0x104–0x106, 0x10A, 0x140–0x144, 0x180, 0x302 and 0x303 exist only with supervisor mode. Addresses 0x306, 0x30A and 0xC00–0xC02 exist only with user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address of the access |
| priv | input | 2 | Current privilege code |
| wr_en | input | 1 | Access writes the register |
| tvm | input | 1 | Trap-virtual-memory control bit |
| mcounten | input | 32 | Machine counter-enable mask |
| scounten | input | 32 | Supervisor counter-enable mask |
| has_smode | input | 1 | Supervisor mode present |
| has_umode | input | 1 | User mode present |
| has_hpm | input | 1 | Performance counters 3..31 present |
| xlen32 | input | 1 | Hart runs in 32-bit mode |
| pmp_count | input | 7 | Number of memory-protection entries (0..64) |
| legal_o | output | 1 | Registered verdict: 1 means the access is permitted |

## Verification
The assertions assume that `priv` never carries the unused code 2'b10. The bench drives only the three defined codes, and one assertion watches for this. They also assume that `pmp_count` stays at 64 or below, and the stimulus uses only the counts 4, 16, 20 and 64. Each configuration input is changed only together with a new access, on the same inactive clock edge, so every registered verdict belongs to exactly one consistent input set.

// File: rtl/csrchk_pkg.sv
package csrchk_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam logic [11:0] A_SEED  = 12'h015;
  localparam logic [11:0] A_XLATE = 12'h180;
  localparam logic [6:0]  BLK_MHPMEV  = 7'h19; // 0x320..0x33F
  localparam logic [6:0]  BLK_MCNT    = 7'h58; // 0xB00..0xB1F
  localparam logic [6:0]  BLK_MCNT_HI = 7'h5C; // 0xB80..0xB9F
  localparam logic [6:0]  BLK_UCNT    = 7'h60; // 0xC00..0xC1F
  localparam logic [6:0]  BLK_UCNT_HI = 7'h64; // 0xC80..0xC9F
endpackage

// File: rtl/csrchk_exist.sv
module csrchk_exist #(
  parameter int ADDR_W = 12,
  parameter int PCNT_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              has_s,
  input  logic              has_u,
  input  logic              has_hpm,
  input  logic              x32,
  input  logic [PCNT_W-1:0] pcount,
  output logic              exists
);
  import csrchk_pkg::*;

  localparam int BLK_W = ADDR_W - 5;

  logic [BLK_W-1:0] blk;
  logic [4:0]       slot;
  logic             slot_hi;
  logic [5:0]       paddr_idx;
  logic [3:0]       pcfg_idx;
  logic             in_pcfg, in_paddr;
  logic             pcfg_ok, paddr_ok;
  logic             fixed_hit;

  assign blk     = addr[ADDR_W-1:5];
  assign slot    = addr[4:0];
  assign slot_hi = (slot >= 5'd3);

  assign pcfg_idx  = addr[3:0];
  assign in_pcfg   = (addr[ADDR_W-1:4] == 8'h3A);
  assign in_paddr  = (addr >= 12'h3B0) && (addr <= 12'h3EF);
  assign paddr_idx = 6'(addr[7:0] - 8'hB0);
  assign pcfg_ok   = ({{(PCNT_W-4){1'b0}}, pcfg_idx} < pcount) && (!pcfg_idx[0] || x32);
  assign paddr_ok  = ({{(PCNT_W-6){1'b0}}, paddr_idx} < pcount);

  always_comb begin
    fixed_hit = 1'b0;
    unique case (addr)
      12'hF11, 12'hF12, 12'hF13, 12'hF14, 12'hF15,
      12'h300, 12'h301, 12'h304, 12'h305, 12'h320,
      12'h340, 12'h341, 12'h342, 12'h343, 12'h344,
      12'hB00, 12'hB02, 12'h7A0, A_SEED:
        fixed_hit = 1'b1;
      12'h302, 12'h303,
      12'h100, 12'h104, 12'h105, 12'h106, 12'h10A,
      12'h140, 12'h141, 12'h142, 12'h143, 12'h144, A_XLATE:
        fixed_hit = has_s;
      12'h306, 12'h30A, 12'hC00, 12'hC01, 12'hC02:
        fixed_hit = has_u;
      12'h310, 12'hB80, 12'hB82:
        fixed_hit = x32;
      12'h31A, 12'hC80, 12'hC81, 12'hC82:
        fixed_hit = has_u && x32;
      default:
        fixed_hit = 1'b0;
    endcase
  end

  always_comb begin
    exists = fixed_hit;
    if (in_pcfg)  exists = pcfg_ok;
    if (in_paddr) exists = paddr_ok;
    if (slot_hi) begin
      if (blk == BLK_MHPMEV || blk == BLK_MCNT) exists = has_hpm;
      if (blk == BLK_MCNT_HI)                   exists = has_hpm && x32;
      if (blk == BLK_UCNT)                      exists = has_hpm && has_u;
      if (blk == BLK_UCNT_HI)                   exists = has_hpm && has_u && x32;
    end
  end
endmodule

// File: rtl/csrchk_field_rules.sv
module csrchk_field_rules #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic              wr,
  input  logic              tvm,
  output logic              fields_ok,
  output logic              xlate_ok,
  output logic              seed_ok
);
  import csrchk_pkg::*;

  logic ro_field;
  logic [1:0] min_priv;

  assign ro_field  = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
  assign min_priv  = addr[ADDR_W-3:ADDR_W-4];
  assign fields_ok = !(wr && ro_field) && (priv >= min_priv);

  assign xlate_ok = !((addr == A_XLATE) && (priv == PRIV_S) && tvm);

  always_comb begin
    seed_ok = 1'b1;
    if (addr == A_SEED) seed_ok = wr && (priv == PRIV_M);
  end
endmodule

// File: rtl/csrchk_ctr_gate.sv
module csrchk_ctr_gate #(
  parameter int ADDR_W = 12,
  parameter int CTR_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic [CTR_W-1:0]  men,
  input  logic [CTR_W-1:0]  sen,
  input  logic              has_s,
  output logic              gate_ok
);
  import csrchk_pkg::*;

  localparam int IDX_W = $clog2(CTR_W);

  logic [IDX_W-1:0] idx;
  logic             in_blk, mbit, sbit;

  assign idx    = addr[IDX_W-1:0];
  assign in_blk = (addr[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'(BLK_UCNT));
  assign mbit   = men[idx];
  assign sbit   = sen[idx];

  always_comb begin
    gate_ok = 1'b1;
    if (in_blk) begin
      unique case (priv)
        PRIV_M:  gate_ok = 1'b1;
        PRIV_S:  gate_ok = mbit;
        default: gate_ok = mbit && (!has_s || sbit);
      endcase
    end
  end
endmodule

// File: rtl/csrchk_top.sv
module csrchk_top #(
  parameter int ADDR_W = 12,
  parameter int CTR_W  = 32,
  parameter int PCNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        priv,
  input  logic              wr_en,
  input  logic              tvm,
  input  logic [CTR_W-1:0]  mcounten,
  input  logic [CTR_W-1:0]  scounten,
  input  logic              has_smode,
  input  logic              has_umode,
  input  logic              has_hpm,
  input  logic              xlen32,
  input  logic [PCNT_W-1:0] pmp_count,
  output logic              legal_o
);
  import csrchk_pkg::*;

  logic exists, fields_ok, xlate_ok, seed_ok, gate_ok, verdict;

  csrchk_exist #(.ADDR_W(ADDR_W), .PCNT_W(PCNT_W)) u_exist (
    .addr(csr_addr), .has_s(has_smode), .has_u(has_umode), .has_hpm(has_hpm),
    .x32(xlen32), .pcount(pmp_count), .exists(exists)
  );

  csrchk_field_rules #(.ADDR_W(ADDR_W)) u_fields (
    .addr(csr_addr), .priv(priv), .wr(wr_en), .tvm(tvm),
    .fields_ok(fields_ok), .xlate_ok(xlate_ok), .seed_ok(seed_ok)
  );

  csrchk_ctr_gate #(.ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_gate (
    .addr(csr_addr), .priv(priv), .men(mcounten), .sen(scounten),
    .has_s(has_smode), .gate_ok(gate_ok)
  );

  assign verdict = exists && fields_ok && xlate_ok && seed_ok && gate_ok;

  always_ff @(posedge clk) begin
    if (rst) legal_o <= 1'b0;
    else     legal_o <= verdict;
  end

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !legal_o); // R1
  AST_PRIV_ENC: assert property (@(posedge clk) disable iff (rst)
    priv != 2'b10); // R4
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && csr_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |=> !legal_o); // R3
  AST_LOW_PRIV: assert property (@(posedge clk) disable iff (rst)
    (priv < csr_addr[ADDR_W-3:ADDR_W-4]) |=> !legal_o); // R4
  AST_XLATE_TRAP: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == A_XLATE && priv == PRIV_S && tvm) |=> !legal_o); // R5
  AST_CTR_SUPER: assert property (@(posedge clk) disable iff (rst)
    (csr_addr[ADDR_W-1:5] == BLK_UCNT && priv == PRIV_S && !mcounten[csr_addr[4:0]])
    |=> !legal_o); // R6
  AST_SEED_READ: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == A_SEED && !wr_en) |=> !legal_o); // R7
  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
    (!xlen32 && csr_addr == 12'h310) |=> !legal_o); // R10
endmodule

// File: tb/csrchk_top_bench.sv
module csrchk_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] d_addr = '0;
  logic [1:0]  d_priv = 2'b11;
  logic        d_wr = 1'b0, d_tvm = 1'b0;
  logic [31:0] d_men = '1, d_sen = '1;
  logic        d_s = 1'b1, d_u = 1'b1, d_hpm = 1'b1, d_x32 = 1'b1;
  logic [6:0]  d_pc = 7'd16;
  logic        legal_o;

  logic        c_tvm = 1'b0;
  logic [31:0] c_men = '1, c_sen = '1;
  logic        c_s = 1'b1, c_u = 1'b1, c_hpm = 1'b1, c_x32 = 1'b1;
  logic [6:0]  c_pc = 7'd16;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; logic [11:0] addr; } item_t;
  item_t sb[$];

  csrchk_top u_csrchk_top (
    .clk(clk), .rst(rst), .csr_addr(d_addr), .priv(d_priv), .wr_en(d_wr),
    .tvm(d_tvm), .mcounten(d_men), .scounten(d_sen), .has_smode(d_s),
    .has_umode(d_u), .has_hpm(d_hpm), .xlen32(d_x32), .pmp_count(d_pc),
    .legal_o(legal_o)
  );

  always #2 clk = ~clk;

  task automatic drive(input logic [11:0] a, input logic [1:0] p, input logic w,
                       input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    d_addr = a; d_priv = p; d_wr = w; d_tvm = c_tvm; d_men = c_men; d_sen = c_sen;
    d_s = c_s; d_u = c_u; d_hpm = c_hpm; d_x32 = c_x32; d_pc = c_pc;
    it.exp = exp; it.tag = tag; it.addr = a;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (legal_o !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%h actual=%b expected=%b", it.tag, it.addr, legal_o, it.exp);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

  initial begin
    d_addr = 12'h300; d_priv = M;
    repeat (3) @(posedge clk);
    #1; checks++;
    if (legal_o !== 1'b0) begin errors++; $display("FAIL R1 reset actual=%b expected=0", legal_o); end
    @(negedge clk); rst = 1'b0;

    drive(12'h300, M, 0, 1, "R1 latency");
    drive(12'h300, S, 0, 0, "R4 machine reg from S");
    drive(12'h100, S, 0, 1, "R4 super reg from S");
    drive(12'h100, U, 0, 0, "R4 super reg from U");
    drive(12'h123, M, 0, 0, "R2 undefined");
    drive(12'h321, M, 0, 0, "R2 undefined 321");
    drive(12'h320, M, 1, 1, "R2 defined 320");
    drive(12'hF11, M, 1, 0, "R3 write ro");
    drive(12'hF11, M, 0, 1, "R3 read ro");
    drive(12'hC00, U, 1, 0, "R3 write user counter");
    drive(12'h180, S, 1, 1, "R5 tvm off");
    c_tvm = 1;
    drive(12'h180, S, 0, 0, "R5 tvm on S");
    drive(12'h180, M, 0, 1, "R5 tvm on M");
    c_tvm = 0;
    c_men = 32'hFFFF_FFFB; c_sen = 32'hFFFF_FFFD;
    drive(12'hC02, S, 0, 0, "R6 S needs mbit");
    drive(12'hC02, M, 0, 1, "R6 M always");
    drive(12'hC01, U, 0, 0, "R6 U needs sbit");
    drive(12'hC01, S, 0, 1, "R6 S with mbit");
    c_s = 0;
    drive(12'hC01, U, 0, 1, "R6 U without smode");
    drive(12'h100, M, 0, 0, "R12 super reg absent");
    drive(12'h302, M, 0, 0, "R12 deleg absent");
    c_s = 1; c_men = '1; c_sen = '1;
    drive(12'h302, M, 0, 1, "R12 deleg present");
    drive(12'h015, M, 0, 0, "R7 seed read");
    drive(12'h015, M, 1, 1, "R7 seed write M");
    drive(12'h015, S, 1, 0, "R7 seed write S");
    drive(12'h015, U, 1, 0, "R7 seed write U");
    c_pc = 7'd4;
    drive(12'h3A3, M, 0, 1, "R8 odd cfg x32");
    drive(12'h3A4, M, 0, 0, "R8 cfg over count");
    c_x32 = 0;
    drive(12'h3A3, M, 0, 0, "R8 odd cfg x64");
    drive(12'h3A2, M, 0, 1, "R8 even cfg x64");
    drive(12'h310, M, 0, 0, "R10 high half x64");
    drive(12'hC80, U, 0, 0, "R10 user high x64");
    drive(12'hB83, M, 0, 0, "R11 high hpm x64");
    c_x32 = 1;
    drive(12'h310, M, 0, 1, "R10 high half x32");
    drive(12'hB80, M, 0, 1, "R10 mcycle high x32");
    drive(12'hC81, U, 0, 1, "R10 user high x32");
    c_pc = 7'd20;
    drive(12'h3C3, M, 0, 1, "R9 addr idx19");
    drive(12'h3C4, M, 0, 0, "R9 addr idx20");
    drive(12'h3B0, M, 0, 1, "R9 addr idx0");
    c_pc = 7'd64;
    drive(12'h3EF, M, 0, 1, "R9 addr idx63");
    drive(12'hB03, M, 0, 1, "R11 mhpm on");
    drive(12'h323, M, 0, 1, "R11 event on");
    drive(12'hC1F, U, 0, 1, "R11 user hpm on");
    drive(12'h322, M, 0, 0, "R11 event idx2 undefined");
    c_hpm = 0;
    drive(12'hB03, M, 0, 0, "R11 mhpm off");
    drive(12'hC03, U, 0, 0, "R11 user hpm off");
    c_hpm = 1; c_u = 0;
    drive(12'h306, M, 0, 0, "R12 counten absent");
    drive(12'hC00, M, 0, 0, "R12 cycle absent");
    drive(12'hC03, M, 0, 0, "R11 user hpm needs umode");
    c_u = 1;

    repeat (4) @(posedge clk);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule